// File: doc/BRIEF.md
# Prioritized Interrupt Vector Arbiter

This block gathers interrupt requests from a parameterised number of channel pairs, five by default, giving ten channels. Each channel keeps a sticky pending flag. A trigger pulse sets the flag, and software can also set it through the register port to raise an interrupt of its own. The interrupt request output stays high while any flag is set.

When the processor pulses the arbitration-start strobe, the block picks one pending channel. Each channel's priority is three bits wide. The top two bits come from a field that software writes, and both channels of a pair share that field. The bottom bit is the channel's parity. The winner's 4-bit code is captured at that moment and does not change until the next strobe. The code is combined with three software-written upper bits to form a byte-wide vector address. An acknowledge pulse retires the pending flag of the captured winner.

The register space is byte-wide. Pending bytes sit at the bottom. The vector byte follows them, and the priority bytes come after that. With the defaults the map is:
- 0: pending flags for channels 0–7
- 1: pending flags for channels 8–9, in bits 1:0
- 2: vector
- 3: priority fields for pairs 0–3
- 4: priority field for pair 4

Unused bits read as 0.

Top module: `irq_arb_top`

## Requirements
- R1: After reset, every pending flag reads 0 and `irq` is 0. Every priority field reads 2'b11, so address 3 reads 8'hFF and address 4 reads 8'h03. Vector bits 4:0 read 5'b11110.
- R2: A one-cycle `trig[c]` pulse sets the pending flag of channel c from the next clock edge. `irq` is high exactly while at least one flag is set.
- R3: Writing a 1 to a pending bit (channel c sits at address c/8, bit c%8) sets that flag. Writing a 0 to a pending bit leaves it unchanged.
- R4: The vector byte is {V[2:0], W[3:0], 1'b0}. A write to address 2 updates only V, from data bits 7:5. Data bits 4:0 of that write are ignored.
- R5: Channel c has priority {field of pair c/2, c%2}. Pair p's field sits in priority byte p/4, bits 2(p%4)+1 : 2(p%4). The lowest numeric priority among pending channels wins.
- R6: When pending channels have equal priority, the lowest-indexed one wins. The winner code W equals the channel index.
- R7: W changes only on the edge where `arb_start` is high. It takes the winner among the flags pending before that edge, or 4'b1111 when none are pending. A trigger that arrives later does not change W until the next strobe.
- R8: `int_ack` clears only the pending flag of channel W. When W is 4'b1111, `int_ack` has no effect.
- R9: When `int_ack` and a trigger for the same winning channel fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 10 | Per-channel trigger pulses, bit c = channel c |
| arb_start | input | 1 | Start-of-arbitration strobe; captures the winner |
| int_ack | input | 1 | Acknowledge of the captured winner |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 3 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| vector | output | 8 | Vector address {V, W, 0} |
| irq | output | 1 | Interrupt request, high while any flag is pending |

## Verification
Two events can land on the same flag in one clock: the acknowledge that retires the captured winner, and a fresh trigger on that same channel. The bench captures a winner with the strobe, then drives `int_ack` and that channel's trigger in the same cycle. It then reads the pending byte back. The flag must still be set, and a later lone acknowledge must clear it. A second overlap is also checked: a higher-priority trigger that arrives after the strobe must leave W unchanged until the next strobe.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int         CODE_W    = 4;
   localparam int         LVL_W     = 3;
   localparam logic [3:0] NO_WINNER = 4'hF;
   typedef logic [LVL_W-1:0] prio_t;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int NCH = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_hw,
   input  logic [NCH-1:0] set_sw,
   input  logic [NCH-1:0] clr_ack,
   output logic [NCH-1:0] pend_q
);
   // A set on the same cycle as a clear wins, so no event is lost.
   for (genvar c = 0; c < NCH; c++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q[c] <= 1'b0;
         else if (set_hw[c] || set_sw[c])
            pend_q[c] <= 1'b1;
         else if (clr_ack[c])
            pend_q[c] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_win_sel.sv
module irq_win_sel
   import irq_arb_pkg::*;
#(
   parameter int NCH = 10
) (
   input  logic [NCH-1:0] pend,
   input  prio_t          prio [NCH],
   output logic [3:0]     code
);
   prio_t best;
   logic  found;

   // Ascending scan with strict compare: ties keep the lower index.
   always_comb begin
      best  = '1;
      found = 1'b0;
      code  = NO_WINNER;
      for (int c = 0; c < NCH; c++) begin
         if (pend[c] && (!found || prio[c] < best)) begin
            found = 1'b1;
            best  = prio[c];
            code  = 4'(c);
         end
      end
   end
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
   import irq_arb_pkg::*;
#(
   parameter int NUM_PAIRS = 5,
   localparam int NCH        = 2 * NUM_PAIRS,
   localparam int PEND_BYTES = (NCH + 7) / 8,
   localparam int PRIO_BYTES = (NUM_PAIRS + 3) / 4,
   localparam int VEC_ADDR   = PEND_BYTES,
   localparam int PRIO_BASE  = PEND_BYTES + 1,
   localparam int NREGS      = PRIO_BASE + PRIO_BYTES,
   localparam int ADDR_W     = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    trig,
   input  logic              arb_start,
   input  logic              int_ack,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic [7:0]        vector,
   output logic              irq
);
   if (NUM_PAIRS < 1 || NCH > 15) begin : g_bad_cfg
      $error("irq_arb_top: NUM_PAIRS must give 1..15 channels");
   end

   logic [NCH-1:0] pend_q;
   logic [NCH-1:0] sw_set;
   logic [NCH-1:0] ack_clr;
   logic [1:0]     lvl_q [NUM_PAIRS];
   prio_t          chan_prio [NCH];
   logic [2:0]     vmsb_q;
   logic [3:0]     win_q;
   logic [3:0]     sel_code;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      assign chan_prio[c] = {lvl_q[c/2], 1'(c % 2)};
      assign sw_set[c]    = reg_wr && (reg_addr == ADDR_W'(c / 8)) && reg_wdata[c % 8];
      assign ack_clr[c]   = int_ack && (win_q == 4'(c));
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            lvl_q[p] <= 2'b11;
         else if (reg_wr && reg_addr == ADDR_W'(PRIO_BASE + p / 4))
            lvl_q[p] <= reg_wdata[2*(p%4) +: 2];
      end
   end

   irq_pend_bank #(.NCH(NCH)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_hw  (trig),
      .set_sw  (sw_set),
      .clr_ack (ack_clr),
      .pend_q  (pend_q)
   );

   irq_win_sel #(.NCH(NCH)) u_sel (
      .pend (pend_q),
      .prio (chan_prio),
      .code (sel_code)
   );

   // Upper vector bits carry no reset value.
   always_ff @(posedge clk) begin
      if (reg_wr && reg_addr == ADDR_W'(VEC_ADDR))
         vmsb_q <= reg_wdata[7:5];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= NO_WINNER;
      else if (arb_start)
         win_q <= sel_code;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(VEC_ADDR))
         reg_rdata = vector;
      for (int c = 0; c < NCH; c++)
         if (reg_addr == ADDR_W'(c / 8))
            reg_rdata[c % 8] = pend_q[c];
      for (int p = 0; p < NUM_PAIRS; p++)
         if (reg_addr == ADDR_W'(PRIO_BASE + p / 4))
            reg_rdata[2*(p%4) +: 2] = lvl_q[p];
   end

   assign vector = {vmsb_q, win_q, 1'b0};
   assign irq    = |pend_q;
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
   parameter int NCH = 10
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] trig,
   input logic           arb_start,
   input logic           int_ack,
   input logic [7:0]     vector,
   input logic           irq,
   input logic [NCH-1:0] pend,
   input logic [3:0]     win
);
   p_trig_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|trig) |=> irq);

   p_w_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !arb_start |=> $stable(vector[4:1]));

   p_nowin_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_start && pend == '0) |=> vector[4:1] == 4'hF);

   p_ack_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && win < 4'(NCH) && !trig[win]) |=> !pend[$past(win)]);

   p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && win < 4'(NCH) && trig[win]) |=> pend[$past(win)]);
endmodule

bind irq_arb_top irq_arb_chk #(.NCH(NCH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig      (trig),
   .arb_start (arb_start),
   .int_ack   (int_ack),
   .vector    (vector),
   .irq       (irq),
   .pend      (pend_q),
   .win       (win_q)
);

// File: tb/test_irq_arb_top.sv
module test_irq_arb_top;
   localparam int NCH = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [NCH-1:0] trig = '0;
   logic       arb_start = 1'b0;
   logic       int_ack = 1'b0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [7:0] vector;
   logic       irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_arb_top i_irq_arb_top (
      .clk(clk), .rst_n(rst_n), .trig(trig), .arb_start(arb_start),
      .int_ack(int_ack), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vector(vector), .irq(irq)
   );

   // {pending mask[9:0], priority fields[9:0], expected W[3:0]}
   localparam logic [23:0] TAB [7] = '{
      {10'h001, 10'h3FF, 4'd0},
      {10'h028, 10'h3FF, 4'd3},
      {10'h006, 10'h3F3, 4'd2},
      {10'h300, 10'h0FF, 4'd8},
      {10'h201, 10'h1FD, 4'd0},
      {10'h012, 10'h3EE, 4'd4},
      {10'h000, 10'h3FF, 4'd15}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [7:0] mask,
                         input logic [7:0] exp, input string req);
      reg_addr = a; #1;
      chk(req, int'(reg_rdata & mask), int'(exp));
   endtask

   task automatic pulse_trig(input logic [NCH-1:0] m);
      @(negedge clk); trig = m;
      @(negedge clk); trig = '0;
   endtask

   task automatic arb();
      @(negedge clk); arb_start = 1'b1;
      @(negedge clk); arb_start = 1'b0;
   endtask

   task automatic ack(input logic [NCH-1:0] m);
      @(negedge clk); int_ack = 1'b1; trig = m;
      @(negedge clk); int_ack = 1'b0; trig = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      rd_chk(3'd0, 8'hFF, 8'h00, "R1 pending lo");
      rd_chk(3'd1, 8'hFF, 8'h00, "R1 pending hi");
      rd_chk(3'd3, 8'hFF, 8'hFF, "R1 prio lo");
      rd_chk(3'd4, 8'hFF, 8'h03, "R1 prio hi");
      chk("R1 vector low bits", int'(vector[4:0]), 5'h1E);
      chk("R1 irq", int'(irq), 0);

      // R5/R6/R7 priority table
      for (int i = 0; i < 7; i++) begin
         do_reset();
         wr(3'd3, TAB[i][11:4]);
         wr(3'd4, {6'b0, TAB[i][13:12]});
         if (TAB[i][23:14] != '0) pulse_trig(TAB[i][23:14]);
         arb();
         chk($sformatf("R5 R6 entry %0d winner", i), int'(vector[4:1]), int'(TAB[i][3:0]));
         chk($sformatf("R2 entry %0d irq", i), int'(irq), int'(TAB[i][23:14] != '0));
      end

      // R3 software set and write-zero
      do_reset();
      wr(3'd1, 8'h01);
      rd_chk(3'd1, 8'hFF, 8'h01, "R3 sw set ch8");
      wr(3'd1, 8'h00);
      rd_chk(3'd1, 8'hFF, 8'h01, "R3 write zero ignored");
      chk("R2 irq from sw set", int'(irq), 1);

      // R4 vector format
      wr(3'd2, 8'hFF);
      chk("R4 vector all V", int'(vector), 8'hFE);
      wr(3'd2, 8'hA0);
      rd_chk(3'd2, 8'hFF, 8'hBE, "R4 vector readback");

      // R8 ack with no winner
      do_reset();
      pulse_trig(10'h002);
      ack('0);
      rd_chk(3'd0, 8'hFF, 8'h02, "R8 ack without winner");

      // R7 freeze then R8 selective clear
      do_reset();
      wr(3'd3, 8'hFC);               // pair0 field 00
      pulse_trig(10'h004);           // ch2 prio 110
      arb();
      chk("R7 first winner", int'(vector[4:1]), 2);
      pulse_trig(10'h001);           // ch0 prio 000 arrives late
      chk("R7 late request held off", int'(vector[4:1]), 2);
      arb();
      chk("R7 next cycle winner", int'(vector[4:1]), 0);
      ack('0);
      rd_chk(3'd0, 8'hFF, 8'h04, "R8 ack clears only winner");

      // R9 ack and trigger of the same winner together
      arb();
      chk("R9 winner is ch2", int'(vector[4:1]), 2);
      ack(10'h004);
      rd_chk(3'd0, 8'hFF, 8'h04, "R9 trigger beats ack");
      ack('0);
      rd_chk(3'd0, 8'hFF, 8'h00, "R8 lone ack clears");
      chk("R2 irq low when empty", int'(irq), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule